// File: doc/BRIEF.md
# Affine Candidate Triplet Constructor

This block forms one affine control-point motion vector predictor triplet for a coding unit. It reads the translational motion vectors of seven 4x4 neighbours, each with an availability flag, together with coded CU width and height. The neighbours fall into three groups: corner group zero holds neighbours 0, 1 and 2, group one holds neighbours 3 and 4, and group two holds neighbours 5 and 6. Every choice of one member from each group is a candidate triplet. For each candidate the block extrapolates the group-two vector from the other two vectors. It scores the candidate by the squared distance between that extrapolation and the actual group-two vector, and keeps the cheapest triplet.

A one-cycle `start` in the idle state captures all inputs. When a group has no available member, or a size code is illegal, the block goes straight to its finish state. Otherwise it scans the twelve combinations, one per clock, in the SCAN state. It then raises `done` for one cycle with `valid` showing whether a triplet was found. The states are IDLE, SCAN and DONE. The transitions are IDLE to SCAN (start with a legal request), IDLE to DONE (start with an empty group or a bad code), SCAN to SCAN (more combinations), SCAN to DONE (last combination) and DONE to IDLE (always).

Top module: `affine_triplet_builder`

## Requirements
- R1: The output triplet is the lowest-cost combination of one neighbour from {0,1,2}, one from {3,4} and one from {5,6}. Output 0 carries the group-zero vector, output 1 the group-one vector and output 2 the group-two vector.
- R2: A neighbour whose availability bit (bit i for neighbour i) is 0 takes part in no combination.
- R3: The predicted group-two vector uses r = h/w, where the size code maps 0 to 16, 1 to 32 and 2 to 64. The horizontal part is P0.hor − floor((P1.ver − P0.ver)·r). The vertical part is P0.ver + floor((P1.hor − P0.hor)·r). Scaling by r is done by shifting, and bits shifted out are floored.
- R4: The cost is dh² + dv² between the actual and predicted group-two vector, computed exactly with no overflow for any 16-bit two's-complement inputs. The best cost never rises during a scan.
- R5: Combinations are visited with the group-zero index outermost and the group-two index innermost. On equal cost the earlier combination is kept.
- R6: If any group has no available neighbour, `done` rises in the first cycle after `start`, `valid` is 0 and all six output components are 0.
- R7: A width or height code of 3 gives `done` in the first cycle after `start` with `valid` 0 and zero outputs.
- R8: For a legal request, `done` is high for exactly one cycle, 13 cycles after the `start` edge. `valid` and the triplet hold until the next accepted `start`.
- R9: `start` is ignored while the block is in SCAN or DONE, and input changes during that time do not affect the result.
- R10: After reset, `done` and `valid` are 0 and the triplet outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted in IDLE only |
| nb_avail | input | 7 | Availability flag per neighbour |
| nb_mv_hor | input | 112 | Horizontal MV per neighbour, neighbour i in bits [16i+15:16i] |
| nb_mv_ver | input | 112 | Vertical MV per neighbour, same packing |
| cu_w_code | input | 2 | Width code: 0=16, 1=32, 2=64, 3 illegal |
| cu_h_code | input | 2 | Height code, same encoding |
| done | output | 1 | One-cycle completion strobe |
| valid | output | 1 | A triplet was found |
| mvp0_hor | output | 16 | Group-zero vector, horizontal |
| mvp0_ver | output | 16 | Group-zero vector, vertical |
| mvp1_hor | output | 16 | Group-one vector, horizontal |
| mvp1_ver | output | 16 | Group-one vector, vertical |
| mvp2_hor | output | 16 | Group-two vector, horizontal |
| mvp2_ver | output | 16 | Group-two vector, vertical |

## Verification
The properties assume that the only way into SCAN is a `start` seen in IDLE. They also assume that availability flags and size codes are latched at that moment, so the checks on a reported triplet refer to the latched copies and not to the live pins. The stimulus always drives `start` as a single-cycle pulse away from the clock edge. It deliberately pokes `start` with altered inputs in mid-scan so that the latched view is tested against live pins that disagree. Vectors stay within 16-bit two's complement, including both extremes, so the no-overflow claim is exercised at its edge.

// File: rtl/affine_cand_pkg.sv
package affine_cand_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } build_state_t;

    localparam logic [1:0] SIZE_CODE_BAD = 2'd3;

endpackage

// File: rtl/affine_cost_unit.sv
// Extrapolates the third control-point vector from the first two and
// returns the squared distance to the supplied third vector.
module affine_cost_unit #(
    parameter  int MV_W   = 16,
    localparam int EW     = MV_W + 5,
    localparam int COST_W = 2 * EW + 1
) (
    input  logic signed [MV_W-1:0] s0_h,
    input  logic signed [MV_W-1:0] s0_v,
    input  logic signed [MV_W-1:0] s1_h,
    input  logic signed [MV_W-1:0] s1_v,
    input  logic signed [MV_W-1:0] s2_h,
    input  logic signed [MV_W-1:0] s2_v,
    input  logic signed [2:0]      ratio_sh,   // log2(h/w), -2..2
    output logic [COST_W-1:0]      cost
);
    logic signed [EW-1:0]   d_h, d_v, sc_h, sc_v, pr_h, pr_v, e_h, e_v;
    logic        [1:0]      rsh_mag;
    logic signed [2*EW-1:0] q_h, q_v;

    always_comb begin
        d_h     = EW'(s1_h) - EW'(s0_h);
        d_v     = EW'(s1_v) - EW'(s0_v);
        rsh_mag = 2'(-ratio_sh);
        if (!ratio_sh[2]) begin
            sc_h = d_h <<< ratio_sh[1:0];
            sc_v = d_v <<< ratio_sh[1:0];
        end else begin
            // arithmetic right shift floors toward minus infinity
            sc_h = d_h >>> rsh_mag;
            sc_v = d_v >>> rsh_mag;
        end
        pr_h = EW'(s0_h) - sc_v;
        pr_v = EW'(s0_v) + sc_h;
        e_h  = EW'(s2_h) - pr_h;
        e_v  = EW'(s2_v) - pr_v;
        q_h  = e_h * e_h;
        q_v  = e_v * e_v;
        cost = COST_W'($unsigned(q_h)) + COST_W'($unsigned(q_v));
    end

endmodule

// File: rtl/affine_combo_iter.sv
// Nested index walker: group-zero index outermost, group-two innermost.
module affine_combo_iter #(
    parameter  int N0 = 3,
    parameter  int N1 = 2,
    parameter  int N2 = 2,
    localparam int W0 = (N0 > 1) ? $clog2(N0) : 1,
    localparam int W1 = (N1 > 1) ? $clog2(N1) : 1,
    localparam int W2 = (N2 > 1) ? $clog2(N2) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [W0-1:0] idx0,
    output logic [W1-1:0] idx1,
    output logic [W2-1:0] idx2,
    output logic          last
);
    logic end0, end1, end2;

    assign end0 = (idx0 == W0'(N0 - 1));
    assign end1 = (idx1 == W1'(N1 - 1));
    assign end2 = (idx2 == W2'(N2 - 1));
    assign last = end0 && end1 && end2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx0 <= '0;
            idx1 <= '0;
            idx2 <= '0;
        end else if (clear) begin
            idx0 <= '0;
            idx1 <= '0;
            idx2 <= '0;
        end else if (step) begin
            if (!end2) begin
                idx2 <= idx2 + 1'b1;
            end else begin
                idx2 <= '0;
                if (!end1) begin
                    idx1 <= idx1 + 1'b1;
                end else begin
                    idx1 <= '0;
                    idx0 <= end0 ? '0 : idx0 + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/affine_triplet_builder.sv
module affine_triplet_builder
    import affine_cand_pkg::*;
#(
    parameter int MV_W = 16,
    parameter int G0   = 3,
    parameter int G1   = 2,
    parameter int G2   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [G0+G1+G2-1:0]    nb_avail,
    input  logic [(G0+G1+G2)*MV_W-1:0] nb_mv_hor,
    input  logic [(G0+G1+G2)*MV_W-1:0] nb_mv_ver,
    input  logic [1:0]             cu_w_code,
    input  logic [1:0]             cu_h_code,
    output logic                   done,
    output logic                   valid,
    output logic [MV_W-1:0]        mvp0_hor,
    output logic [MV_W-1:0]        mvp0_ver,
    output logic [MV_W-1:0]        mvp1_hor,
    output logic [MV_W-1:0]        mvp1_ver,
    output logic [MV_W-1:0]        mvp2_hor,
    output logic [MV_W-1:0]        mvp2_ver
);
    localparam int NB     = G0 + G1 + G2;
    localparam int IW     = $clog2(NB);
    localparam int COST_W = 2 * (MV_W + 5) + 1;
    localparam int W0     = (G0 > 1) ? $clog2(G0) : 1;
    localparam int W1     = (G1 > 1) ? $clog2(G1) : 1;
    localparam int W2     = (G2 > 1) ? $clog2(G2) : 1;

    build_state_t state, state_nx;

    logic signed [MV_W-1:0] mvh_q [NB];
    logic signed [MV_W-1:0] mvv_q [NB];
    logic [NB-1:0]          avail_q;
    logic [1:0]             w_q, h_q;
    logic [COST_W-1:0]      best_cost;
    logic [IW-1:0]          bp0, bp1, bp2;
    logic                   found_q;

    // request qualification on live pins
    logic g0_any, g1_any, g2_any, codes_ok, launch_ok, accept;
    assign g0_any    = |nb_avail[G0-1:0];
    assign g1_any    = |nb_avail[G0+G1-1:G0];
    assign g2_any    = |nb_avail[NB-1:G0+G1];
    assign codes_ok  = (cu_w_code != SIZE_CODE_BAD) && (cu_h_code != SIZE_CODE_BAD);
    assign launch_ok = codes_ok && g0_any && g1_any && g2_any;
    assign accept    = (state == ST_IDLE) && start;

    // combination walker
    logic [W0-1:0] idx0;
    logic [W1-1:0] idx1;
    logic [W2-1:0] idx2;
    logic          walk_last, scanning;
    assign scanning = (state == ST_SCAN);

    affine_combo_iter #(.N0(G0), .N1(G1), .N2(G2)) u_iter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (scanning),
        .idx0  (idx0),
        .idx1  (idx1),
        .idx2  (idx2),
        .last  (walk_last)
    );

    logic [IW-1:0] p0, p1, p2;
    logic          combo_ok;
    assign p0       = IW'(idx0);
    assign p1       = IW'(G0) + IW'(idx1);
    assign p2       = IW'(G0 + G1) + IW'(idx2);
    assign combo_ok = avail_q[p0] && avail_q[p1] && avail_q[p2];

    logic signed [2:0]  ratio_sh;
    logic [COST_W-1:0]  cand_cost;
    assign ratio_sh = $signed({1'b0, h_q}) - $signed({1'b0, w_q});

    affine_cost_unit #(.MV_W(MV_W)) u_cost (
        .s0_h     (mvh_q[p0]),
        .s0_v     (mvv_q[p0]),
        .s1_h     (mvh_q[p1]),
        .s1_v     (mvv_q[p1]),
        .s2_h     (mvh_q[p2]),
        .s2_v     (mvv_q[p2]),
        .ratio_sh (ratio_sh),
        .cost     (cand_cost)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = launch_ok ? ST_SCAN : ST_DONE;
            ST_SCAN: if (walk_last) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // capture and best-candidate tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                mvh_q[i] <= '0;
                mvv_q[i] <= '0;
            end
            avail_q   <= '0;
            w_q       <= '0;
            h_q       <= '0;
            best_cost <= '1;
            bp0       <= '0;
            bp1       <= '0;
            bp2       <= '0;
            found_q   <= 1'b0;
        end else if (accept) begin
            for (int i = 0; i < NB; i++) begin
                mvh_q[i] <= nb_mv_hor[i*MV_W +: MV_W];
                mvv_q[i] <= nb_mv_ver[i*MV_W +: MV_W];
            end
            avail_q   <= nb_avail;
            w_q       <= cu_w_code;
            h_q       <= cu_h_code;
            best_cost <= '1;
            found_q   <= 1'b0;
        end else if (scanning && combo_ok && (cand_cost < best_cost)) begin
            best_cost <= cand_cost;
            bp0       <= p0;
            bp1       <= p1;
            bp2       <= p2;
            found_q   <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        done     = (state == ST_DONE);
        valid    = found_q;
        mvp0_hor = found_q ? mvh_q[bp0] : '0;
        mvp0_ver = found_q ? mvv_q[bp0] : '0;
        mvp1_hor = found_q ? mvh_q[bp1] : '0;
        mvp1_ver = found_q ? mvv_q[bp1] : '0;
        mvp2_hor = found_q ? mvh_q[bp2] : '0;
        mvp2_ver = found_q ? mvv_q[bp2] : '0;
    end

endmodule

// File: rtl/affine_triplet_checker.sv
module affine_triplet_checker
    import affine_cand_pkg::*;
#(
    parameter int MV_W   = 16,
    parameter int NB     = 7,
    parameter int IW     = 3,
    parameter int COST_W = 43
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              valid,
    input logic [MV_W-1:0]   mvp0_hor,
    input logic [MV_W-1:0]   mvp0_ver,
    input logic [MV_W-1:0]   mvp1_hor,
    input logic [MV_W-1:0]   mvp1_ver,
    input logic [MV_W-1:0]   mvp2_hor,
    input logic [MV_W-1:0]   mvp2_ver,
    input build_state_t      state,
    input logic [COST_W-1:0] best_cost,
    input logic [1:0]        w_q,
    input logic [1:0]        h_q,
    input logic [NB-1:0]     avail_q,
    input logic [IW-1:0]     bp0,
    input logic [IW-1:0]     bp1,
    input logic [IW-1:0]     bp2
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_on_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (mvp0_hor == '0 && mvp0_ver == '0 && mvp1_hor == '0 &&
                              mvp1_ver == '0 && mvp2_hor == '0 && mvp2_ver == '0));

    assert_codes_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (w_q != SIZE_CODE_BAD && h_q != SIZE_CODE_BAD));

    assert_sel_available_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> (avail_q[bp0] && avail_q[bp1] && avail_q[bp2]));

    assert_cost_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && $past(state) == ST_SCAN) |-> (best_cost <= $past(best_cost)));

    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(avail_q) && $stable(w_q) && $stable(h_q)));

endmodule

bind affine_triplet_builder affine_triplet_checker #(
    .MV_W(MV_W), .NB(NB), .IW(IW), .COST_W(COST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .valid     (valid),
    .mvp0_hor  (mvp0_hor),
    .mvp0_ver  (mvp0_ver),
    .mvp1_hor  (mvp1_hor),
    .mvp1_ver  (mvp1_ver),
    .mvp2_hor  (mvp2_hor),
    .mvp2_ver  (mvp2_ver),
    .state     (state),
    .best_cost (best_cost),
    .w_q       (w_q),
    .h_q       (h_q),
    .avail_q   (avail_q),
    .bp0       (bp0),
    .bp1       (bp1),
    .bp2       (bp2)
);

// File: tb/tb_affine_triplet_builder.sv
module tb_affine_triplet_builder;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [6:0]   nb_avail = '0;
    logic [111:0] nb_mv_hor = '0;
    logic [111:0] nb_mv_ver = '0;
    logic [1:0]   cu_w_code = '0;
    logic [1:0]   cu_h_code = '0;
    logic         done, valid;
    logic [15:0]  mvp0_hor, mvp0_ver, mvp1_hor, mvp1_ver, mvp2_hor, mvp2_ver;

    int checks = 0;
    int fails  = 0;

    int mh [7];
    int mv [7];
    bit [6:0] av;
    int wc, hc;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    affine_triplet_builder dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .nb_avail(nb_avail), .nb_mv_hor(nb_mv_hor), .nb_mv_ver(nb_mv_ver),
        .cu_w_code(cu_w_code), .cu_h_code(cu_h_code),
        .done(done), .valid(valid),
        .mvp0_hor(mvp0_hor), .mvp0_ver(mvp0_ver),
        .mvp1_hor(mvp1_hor), .mvp1_ver(mvp1_ver),
        .mvp2_hor(mvp2_hor), .mvp2_ver(mvp2_ver)
    );

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic int scale(input int x, input int s);
        if (s >= 0) return x * (1 << s);
        return x >>> (-s);
    endfunction

    // behavioural reference: exhaustive search in visiting order
    task automatic model(output bit ev, output int e[6]);
        longint best = 64'sh7FFF_FFFF_FFFF_FFFF;
        ev = 1'b0;
        for (int k = 0; k < 6; k++) e[k] = 0;
        if (wc == 3 || hc == 3) return;
        for (int a = 0; a < 3; a++)
            for (int d = 3; d < 5; d++)
                for (int f = 5; f < 7; f++) begin
                    int s, ph, pv, eh, evv;
                    longint c;
                    if (!(av[a] && av[d] && av[f])) continue;
                    s   = hc - wc;
                    ph  = mh[a] - scale(mv[d] - mv[a], s);
                    pv  = mv[a] + scale(mh[d] - mh[a], s);
                    eh  = mh[f] - ph;
                    evv = mv[f] - pv;
                    c   = longint'(eh) * eh + longint'(evv) * evv;
                    if (c < best) begin
                        best = c; ev = 1'b1;
                        e[0] = mh[a]; e[1] = mv[a]; e[2] = mh[d];
                        e[3] = mv[d]; e[4] = mh[f]; e[5] = mv[f];
                    end
                end
    endtask

    task automatic check(input string req, input string what, input bit ok,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive();
        nb_avail  = av;
        cu_w_code = 2'(wc);
        cu_h_code = 2'(hc);
        for (int i = 0; i < 7; i++) begin
            nb_mv_hor[i*16 +: 16] = 16'(mh[i]);
            nb_mv_ver[i*16 +: 16] = 16'(mv[i]);
        end
    endtask

    // one request; done compared against the model on every clock
    task automatic run(input string req, input bit poke);
        bit ev;
        int e[6];
        int act[6];
        int expc;
        bit timing_ok = 1'b1;
        int bad_c = 0;
        model(ev, e);
        expc = (wc == 3 || hc == 3 || !(|av[2:0]) || !(|av[4:3]) || !(|av[6:5])) ? 1 : 13;
        @(negedge clk);
        drive();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 16; c++) begin
            if (done !== (c == expc)) begin
                if (timing_ok) bad_c = c;
                timing_ok = 1'b0;
            end
            if (c == expc) begin
                act[0] = int'($signed(mvp0_hor)); act[1] = int'($signed(mvp0_ver));
                act[2] = int'($signed(mvp1_hor)); act[3] = int'($signed(mvp1_ver));
                act[4] = int'($signed(mvp2_hor)); act[5] = int'($signed(mvp2_ver));
                check(req, "valid", valid === ev, longint'(valid), longint'(ev));
                for (int k = 0; k < 6; k++)
                    check(req, $sformatf("component %0d", k), act[k] == e[k], act[k], e[k]);
            end
            if (poke && c == 3) begin
                start = 1'b1; nb_avail = 7'h00; cu_w_code = 2'd3;
            end
            if (c == 4) start = 1'b0;
            @(negedge clk);
        end
        check("R8", {req, " done timing"}, timing_ok, bad_c, expc);
    endtask

    task automatic set_all(input int h0, input int v0);
        for (int i = 0; i < 7; i++) begin mh[i] = h0; mv[i] = v0; end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", "done", done === 1'b0, longint'(done), 0);
        check("R10", "valid", valid === 1'b0, longint'(valid), 0);
        check("R10", "mvp0_hor", mvp0_hor === 16'd0, longint'(mvp0_hor), 0);
        check("R10", "mvp2_ver", mvp2_ver === 16'd0, longint'(mvp2_ver), 0);

        // R1 all neighbours available, square CU
        mh = '{5, -7, 12, 30, -3, 8, 40};
        mv = '{-2, 9, 4, 11, 1, 33, -6};
        av = 7'h7F; wc = 1; hc = 1;
        run("R1", 1'b0);

        // R2 sparse availability
        av = 7'b0110101; run("R2", 1'b0);

        // R3 tall CU (h/w = 4) and wide CU (h/w = 1/4) with negative deltas
        av = 7'h7F; wc = 0; hc = 2; run("R3", 1'b0);
        mh = '{0, 3, -9, -5, -7, 2, -1};
        mv = '{0, -4, 6, -5, 3, -1, 2};
        wc = 2; hc = 0; run("R3", 1'b0);
        wc = 2; hc = 1; run("R3", 1'b0);

        // R4 extreme magnitudes
        mh = '{32767, -32768, 32767, -32768, 32767, 32767, -32768};
        mv = '{-32768, 32767, -32768, 32767, -32768, -32768, 32767};
        av = 7'h7F; wc = 0; hc = 2; run("R4", 1'b0);

        // R5 tie: only A, D available; F and G equally distant from prediction
        set_all(0, 0);
        mh[3] = 10; mv[3] = 0;
        mh[5] = 1;  mv[5] = 10;
        mh[6] = -1; mv[6] = 10;
        av = 7'b1101001; wc = 1; hc = 1; run("R5", 1'b0);

        // R6 empty group one, then empty group two
        av = 7'b1100111; run("R6", 1'b0);
        av = 7'b0011111; run("R6", 1'b0);

        // R7 illegal size codes
        av = 7'h7F; wc = 3; hc = 1; run("R7", 1'b0);
        wc = 0; hc = 3; run("R7", 1'b0);

        // R9 start with changed inputs mid-scan is ignored
        mh = '{4, -8, 15, 22, -6, 9, 31};
        mv = '{7, -3, 2, 18, 5, 25, -11};
        av = 7'h7F; wc = 1; hc = 2; run("R9", 1'b1);

        // R1 pseudo-random sweep over sizes and availability
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < 7; i++) begin
                int span = (n % 4 == 0) ? 65536 : 256;
                mh[i] = int'(rnd() % span) - span / 2;
                mv[i] = int'(rnd() % span) - span / 2;
            end
            av = 7'(rnd()) | ((n % 3 == 0) ? 7'h7F : 7'h00);
            wc = int'(rnd() % 3);
            hc = int'(rnd() % 3);
            run("R1", 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule